// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This engine copies data from system memory into a fixed video-RAM window in 16-byte blocks. The CPU loads four address byte registers: source high, source low, destination high and destination low. It then writes a control register, which checks the request and either starts a copy or refuses it. Bit 7 of the control value chooses the mode. With bit 7 clear, the whole transfer runs in one go and the CPU is stalled throughout. With bit 7 set, one block moves on each rising edge of the horizontal-blank input, and the CPU is stalled only while that block moves.

The engine drives a byte-wide bus master port. Each byte takes two cycles: a read cycle at the source address, then a write cycle at the destination address. The control register readback shows the remaining block count while a transfer runs. It shows a status code when a request is refused, cancelled or finished.

Top module: `vram_dma`

## Requirements
- R1: After reset the control readback is 0xFF, the CPU stall output is low, and both bus strobes are low.
- R2: Register select codes are 0 source high, 1 source low, 2 destination high, 3 destination low, 4 control. The source address is {source high, source low} with its low 4 bits cleared. The first read of an accepted transfer goes to that address.
- R3: The destination address keeps bits 12..4 of {destination high, destination low} and is forced into the window 0x8000–0x9FF0. When it advances past 0x9FF0 it wraps to 0x8000. Every write lands in 0x8000–0x9FFF.
- R4: A control write while idle whose aligned source lies in 0x8000–0x9FFF starts nothing. The readback becomes the written value with bit 7 set.
- R5: A control write while idle with bit 7 clear, and a valid source, raises the CPU stall output in the next cycle. The whole transfer then runs back to back, 32 cycles per block, and the stall drops when it ends.
- R6: A control write while idle with bit 7 set while the LCD enable input is low starts nothing. The readback becomes 0x80 | ((value + 1) & 0x7F).
- R7: On an accepted start the readback becomes the written value with bit 7 cleared.
- R8: A transfer moves ((value & 0x7F) + 1) blocks of 16 bytes.
- R9: In blank-period mode, exactly one block moves per rising edge of the hblank input. The stall output is high for the 32 cycles of that block and low otherwise. A level held high does not start a second block.
- R10: After each block the low 7 bits of the readback count down by one. When the block with count 0 finishes, the readback becomes 0xFF and the engine goes idle.
- R11: A control write with bit 7 clear during an active blank-period transfer, between blocks, cancels it. The readback keeps its count with bit 7 set, and later hblank edges move nothing.
- R12: Each byte is a read cycle at the source address followed by a write cycle of that byte at the destination address. The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0..4) |
| cfg_wdata | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Control register readback |
| lcd_on | input | 1 | LCD enable level |
| hblank | input | 1 | Horizontal-blank indication |
| cpu_stall | output | 1 | Holds the CPU while bytes move |
| mem_rd | output | 1 | Bus read strobe |
| mem_wr | output | 1 | Bus write strobe |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data, valid in the read cycle |

## Verification
The hardest case to reach is a cancellation that lands between two blank-period blocks with a partial count left. The stimulus starts a four-block transfer and releases one hblank pulse. It waits until the block has fully drained, then writes the control register with bit 7 clear. It then sends further hblank pulses to show that nothing moves. The destination wrap needs a source just below the window and a destination near 0x9FF0, so that a three-block copy crosses both boundaries in one run. A held-high hblank level is also used, to show that only edges count.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_SET    = 2'd1,
        CMD_GO     = 2'd2,
        CMD_CANCEL = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        SEL_SRC_HI = 3'd0,
        SEL_SRC_LO = 3'd1,
        SEL_DST_HI = 3'd2,
        SEL_DST_LO = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/vdma_hbedge.sv
module vdma_hbedge (
    input  logic clk,
    input  logic rst_n,
    input  logic hblank,
    output logic hb_rise
);
    logic hb_d, hb_q;

    always_comb begin
        hb_d = hblank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hb_q <= 1'b1;
        else        hb_q <= hb_d;
    end

    assign hb_rise = hblank & ~hb_q;
endmodule

// File: rtl/vdma_start_check.sv
module vdma_start_check
    import vdma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CTRL_W   = 8,
    parameter int BLK_LOG2 = 4,
    parameter int WIN_LOG2 = 13,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] wval,
    input  logic [ADDR_W-1:0] src_raw,
    input  logic [ADDR_W-1:0] dst_raw,
    input  logic              lcd_on,
    input  logic              active,
    input  logic              hb_mode,
    input  logic              moving,
    output cmd_kind_e         kind,
    output logic              go_hb,
    output logic [CTRL_W-1:0] stat_val,
    output logic [ADDR_W-1:0] src_al,
    output logic [ADDR_W-1:0] dst_al
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-BLK_LOG2){1'b1}}, {BLK_LOG2{1'b0}}};
    localparam logic [ADDR_W-1:0] FIELD_MASK = {{(ADDR_W-WIN_LOG2){1'b0}}, {(WIN_LOG2-BLK_LOG2){1'b1}}, {BLK_LOG2{1'b0}}};
    localparam logic [ADDR_W-1:0] WIN_MASK   = {{(ADDR_W-WIN_LOG2){1'b1}}, {WIN_LOG2{1'b0}}};
    localparam logic [CTRL_W-1:0] MODE_BIT   = {1'b1, {(CTRL_W-1){1'b0}}};
    localparam logic [CTRL_W-1:0] CNT_MASK   = ~MODE_BIT;
    localparam logic [CTRL_W-1:0] ONE_C      = {{(CTRL_W-1){1'b0}}, 1'b1};

    logic              in_win;
    logic [CTRL_W-1:0] inc_v;

    always_comb begin
        src_al   = src_raw & ALIGN_MASK;
        dst_al   = (dst_raw & FIELD_MASK) | (WIN_BASE & WIN_MASK);
        in_win   = (src_al & WIN_MASK) == (WIN_BASE & WIN_MASK);
        inc_v    = wval + ONE_C;
        kind     = CMD_NONE;
        go_hb    = 1'b0;
        stat_val = wval;
        if (ctrl_we) begin
            if (active) begin
                if (hb_mode && !moving && !wval[CTRL_W-1]) kind = CMD_CANCEL;
            end else if (in_win) begin
                kind     = CMD_SET;
                stat_val = wval | MODE_BIT;
            end else if (!wval[CTRL_W-1]) begin
                kind     = CMD_GO;
                stat_val = wval & CNT_MASK;
            end else if (lcd_on) begin
                kind     = CMD_GO;
                go_hb    = 1'b1;
                stat_val = wval & CNT_MASK;
            end else begin
                kind     = CMD_SET;
                stat_val = MODE_BIT | (inc_v & CNT_MASK);
            end
        end
    end
endmodule

// File: rtl/vdma_mover.sv
module vdma_mover
    import vdma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int CTRL_W   = 8,
    parameter int BLK_LOG2 = 4,
    parameter int WIN_LOG2 = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_kind_e         kind,
    input  logic              go_hb,
    input  logic [CTRL_W-1:0] stat_val,
    input  logic [ADDR_W-1:0] go_src,
    input  logic [ADDR_W-1:0] go_dst,
    input  logic              hb_rise,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              active,
    output logic              hb_mode,
    output logic              moving,
    output logic [CTRL_W-1:0] stat,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int FLD_W = WIN_LOG2 - BLK_LOG2;
    localparam logic [BLK_LOG2-1:0] IDX_LAST = '1;
    localparam logic [BLK_LOG2-1:0] IDX_ONE  = {{(BLK_LOG2-1){1'b0}}, 1'b1};
    localparam logic [FLD_W-1:0]    FLD_ONE  = {{(FLD_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0]   BLK_STEP = ADDR_W'(1) << BLK_LOG2;
    localparam logic [CTRL_W-1:0]   STAT_ONE = {{(CTRL_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic              active;
        logic              hb_mode;
        logic              moving;
        logic              wr_ph;
        logic [BLK_LOG2-1:0] idx;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CTRL_W-1:0] stat;
        logic [DATA_W-1:0] rbyte;
    } mv_st_t;

    mv_st_t st_d, st_q;
    logic [FLD_W-1:0]  fld_inc;
    logic [ADDR_W-1:0] dst_adv;

    always_comb begin
        fld_inc = st_q.dst[WIN_LOG2-1:BLK_LOG2] + FLD_ONE;
        dst_adv = {st_q.dst[ADDR_W-1:WIN_LOG2], fld_inc, {BLK_LOG2{1'b0}}};
        st_d    = st_q;
        if (st_q.moving) begin
            if (!st_q.wr_ph) begin
                st_d.rbyte = mem_rdata;
                st_d.wr_ph = 1'b1;
            end else begin
                st_d.wr_ph = 1'b0;
                if (st_q.idx == IDX_LAST) begin
                    st_d.idx = '0;
                    st_d.src = st_q.src + BLK_STEP;
                    st_d.dst = dst_adv;
                    if (st_q.stat[CTRL_W-2:0] == '0) begin
                        st_d.stat   = '1;
                        st_d.active = 1'b0;
                        st_d.moving = 1'b0;
                    end else begin
                        st_d.stat   = st_q.stat - STAT_ONE;
                        st_d.moving = !st_q.hb_mode;
                    end
                end else begin
                    st_d.idx = st_q.idx + IDX_ONE;
                end
            end
        end else if (st_q.active && st_q.hb_mode && hb_rise) begin
            st_d.moving = 1'b1;
        end
        case (kind)
            CMD_SET: st_d.stat = stat_val;
            CMD_GO: begin
                st_d.active  = 1'b1;
                st_d.hb_mode = go_hb;
                st_d.moving  = !go_hb;
                st_d.wr_ph   = 1'b0;
                st_d.idx     = '0;
                st_d.src     = go_src;
                st_d.dst     = go_dst;
                st_d.stat    = stat_val;
            end
            CMD_CANCEL: begin
                st_d.active = 1'b0;
                st_d.moving = 1'b0;
                st_d.stat   = {1'b1, st_q.stat[CTRL_W-2:0]};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stat <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = st_q.active;
    assign hb_mode   = st_q.hb_mode;
    assign moving    = st_q.moving;
    assign stat      = st_q.stat;
    assign mem_rd    = st_q.moving & ~st_q.wr_ph;
    assign mem_wr    = st_q.moving & st_q.wr_ph;
    assign mem_addr  = st_q.wr_ph ? {st_q.dst[ADDR_W-1:BLK_LOG2], st_q.idx}
                                  : {st_q.src[ADDR_W-1:BLK_LOG2], st_q.idx};
    assign mem_wdata = st_q.rbyte;

    assert_rw_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_write_follows_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));
    assert_dst_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[ADDR_W-1:WIN_LOG2] == go_dst[ADDR_W-1:WIN_LOG2]));
    assert_gp_stalls_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_GO && !go_hb) |=> moving);
    assert_flag_means_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat[CTRL_W-1] |-> !moving);
    assert_hb_needs_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hb_mode && !moving && !hb_rise) |=> !moving);
endmodule

// File: rtl/vram_dma.sv
module vram_dma
    import vdma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int CTRL_W   = 8,
    parameter int BLK_LOG2 = 4,
    parameter int WIN_LOG2 = 13,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              lcd_on,
    input  logic              hblank,
    output logic              cpu_stall,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int NREG = 4;

    typedef struct packed {
        logic [NREG-1:0][7:0] b;
    } areg_t;

    areg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        for (int i = 0; i < NREG; i++) begin
            if (cfg_we && cfg_sel == 3'(i)) reg_d.b[i] = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    logic [ADDR_W-1:0] src_raw, dst_raw, src_al, dst_al;
    logic              ctrl_we, hb_rise, go_hb, active, hb_mode, moving;
    logic [CTRL_W-1:0] stat_val;
    cmd_kind_e         kind;

    assign src_raw = ADDR_W'({reg_q.b[SEL_SRC_HI], reg_q.b[SEL_SRC_LO]});
    assign dst_raw = ADDR_W'({reg_q.b[SEL_DST_HI], reg_q.b[SEL_DST_LO]});
    assign ctrl_we = cfg_we && (cfg_sel == SEL_CTRL);

    vdma_hbedge u_edge (
        .clk(clk), .rst_n(rst_n), .hblank(hblank), .hb_rise(hb_rise)
    );

    vdma_start_check #(
        .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .BLK_LOG2(BLK_LOG2),
        .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)
    ) u_check (
        .ctrl_we(ctrl_we), .wval(CTRL_W'(cfg_wdata)), .src_raw(src_raw),
        .dst_raw(dst_raw), .lcd_on(lcd_on), .active(active),
        .hb_mode(hb_mode), .moving(moving), .kind(kind), .go_hb(go_hb),
        .stat_val(stat_val), .src_al(src_al), .dst_al(dst_al)
    );

    vdma_mover #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
        .BLK_LOG2(BLK_LOG2), .WIN_LOG2(WIN_LOG2)
    ) u_mover (
        .clk(clk), .rst_n(rst_n), .kind(kind), .go_hb(go_hb),
        .stat_val(stat_val), .go_src(src_al), .go_dst(dst_al),
        .hb_rise(hb_rise), .mem_rdata(mem_rdata), .active(active),
        .hb_mode(hb_mode), .moving(moving), .stat(ctrl_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    assign cpu_stall = moving;

    assert_reject_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !active && (src_raw[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]))
        |=> (ctrl_rdata[CTRL_W-1] && !cpu_stall));
endmodule

// File: tb/vram_dma_bench.sv
module vram_dma_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, cfg_we, lcd_on, hblank;
    logic [2:0]  cfg_sel;
    logic [7:0]  cfg_wdata, ctrl_rdata, mem_wdata, mem_rdata;
    logic        cpu_stall, mem_rd, mem_wr;
    logic [15:0] mem_addr;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    assign mem_rdata = memf(mem_addr);

    vram_dma u_vram_dma (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ctrl_rdata(ctrl_rdata), .lcd_on(lcd_on),
        .hblank(hblank), .cpu_stall(cpu_stall), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    int n_checks = 0;
    int n_errors = 0;
    int wr_count = 0;
    int stall_count = 0;
    int cycles = 0;
    logic [15:0] last_wr_addr = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: op queue {wr, last, addr, data}
    logic [25:0] opq[$];
    bit          m_active, m_hb, hb_prev;
    logic [7:0]  m_stat;
    logic [15:0] m_src, m_dst;
    logic [7:0]  mreg[4];

    task automatic push_block();
        for (int i = 0; i < 16; i++) begin
            logic [15:0] sa;
            logic [15:0] da;
            sa = m_src + 16'(i);
            da = m_dst + 16'(i);
            opq.push_back({1'b0, 1'b0, sa, 8'h00});
            opq.push_back({1'b1, (i == 15), da, memf(sa)});
        end
        m_src = m_src + 16'd16;
        m_dst = 16'h8000 + ((m_dst - 16'h8000 + 16'd16) % 16'h2000);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            opq.delete();
            m_active = 0; m_hb = 0; hb_prev = 1;
            m_stat = 8'hFF;
            for (int i = 0; i < 4; i++) mreg[i] = 8'h00;
        end else begin
            bit was_moving, pre_active, blk_end, cancel;
            logic [25:0] op;
            logic [15:0] sa;
            logic [7:0]  v;
            was_moving = (opq.size() != 0);
            pre_active = m_active;
            blk_end = 0; cancel = 0;
            v = cfg_wdata;
            if (cfg_we && cfg_sel == 3'd4 && pre_active && m_hb && !was_moving && !v[7])
                cancel = 1;
            if (was_moving) begin
                op = opq.pop_front();
                blk_end = op[25] & op[24];
            end
            if (blk_end) begin
                if (m_stat[6:0] == 0) begin m_stat = 8'hFF; m_active = 0; end
                else begin m_stat = m_stat - 8'd1; if (!m_hb) push_block(); end
            end else if (!was_moving && m_active && m_hb && hblank && !hb_prev && !cancel) begin
                push_block();
            end
            if (cfg_we && cfg_sel == 3'd4) begin
                if (cancel) begin
                    m_active = 0; m_stat = m_stat | 8'h80;
                end else if (!pre_active) begin
                    sa = {mreg[0], mreg[1]} & 16'hFFF0;
                    if (sa >= 16'h8000 && sa < 16'hA000) m_stat = v | 8'h80;
                    else if (!v[7] || lcd_on) begin
                        m_src = sa;
                        m_dst = ({mreg[2], mreg[3]} & 16'h1FF0) | 16'h8000;
                        m_active = 1; m_hb = v[7]; m_stat = v & 8'h7F;
                        if (!v[7]) push_block();
                    end else m_stat = 8'h80 | ((v + 8'd1) & 8'h7F);
                end
            end else if (cfg_we && cfg_sel < 3'd4) begin
                mreg[cfg_sel[1:0]] = v;
            end
            hb_prev = hblank;
        end
    end

    // Per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
        if (rst_n) begin
            bit busy;
            logic [25:0] f;
            busy = (opq.size() != 0);
            f = busy ? opq[0] : 26'd0;
            chk(cpu_stall == busy, "R9 stall", cpu_stall, busy);
            chk(mem_rd == (busy && !f[25]), "R12 rd", mem_rd, busy && !f[25]);
            chk(mem_wr == (busy && f[25]), "R12 wr", mem_wr, busy && f[25]);
            if (busy) chk(mem_addr == f[23:8], "R2 addr", mem_addr, f[23:8]);
            if (busy && f[25]) chk(mem_wdata == f[7:0], "R12 data", mem_wdata, f[7:0]);
            chk(ctrl_rdata == m_stat, "R10 readback", ctrl_rdata, m_stat);
            if (mem_wr) begin wr_count++; last_wr_addr = mem_addr; end
            if (cpu_stall) stall_count++;
        end
    end

    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk); #1;
        cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic set_addr(input logic [15:0] s, input logic [15:0] d);
        wr_reg(3'd0, s[15:8]); wr_reg(3'd1, s[7:0]);
        wr_reg(3'd2, d[15:8]); wr_reg(3'd3, d[7:0]);
    endtask

    task automatic clr_counts();
        wr_count = 0; stall_count = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_hb(input int hold);
        @(negedge clk); #1; hblank = 1;
        repeat (hold) @(negedge clk);
        #1; hblank = 0;
    endtask

    initial begin
        rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; lcd_on = 0; hblank = 0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        chk(ctrl_rdata == 8'hFF, "R1 readback", ctrl_rdata, 8'hFF);
        chk(!cpu_stall && !mem_rd && !mem_wr, "R1 idle", {cpu_stall, mem_rd, mem_wr}, 0);

        // R4: source inside the video window
        set_addr(16'h8A37, 16'h0000);
        wr_reg(3'd4, 8'h05);
        chk(ctrl_rdata == 8'h85, "R4 reject", ctrl_rdata, 8'h85);
        clr_counts(); idle(5);
        chk(stall_count == 0, "R4 no stall", stall_count, 0);
        set_addr(16'h9FFF, 16'h0000);
        wr_reg(3'd4, 8'h7F);
        chk(ctrl_rdata == 8'hFF, "R4 top edge", ctrl_rdata, 8'hFF);

        // R5 R7 R8 R2 R3: general copy, crossing into the window wrap
        set_addr(16'h7FFC, 16'hFFE7);
        clr_counts();
        @(negedge clk); #1;
        cfg_we = 1; cfg_sel = 3'd4; cfg_wdata = 8'h02;
        @(negedge clk);
        chk(ctrl_rdata == 8'h02, "R7 accepted", ctrl_rdata, 8'h02);
        chk(cpu_stall == 1, "R5 stall next", cpu_stall, 1);
        chk(mem_rd && mem_addr == 16'h7FF0, "R2 first read", mem_addr, 16'h7FF0);
        #1 cfg_we = 0;
        while (cpu_stall) @(negedge clk);
        #1;
        chk(wr_count == 48, "R8 bytes", wr_count, 48);
        chk(stall_count == 96, "R5 contiguous", stall_count, 96);
        chk(last_wr_addr == 16'h800F, "R3 wrap", last_wr_addr, 16'h800F);
        chk(ctrl_rdata == 8'hFF, "R10 done", ctrl_rdata, 8'hFF);

        // R6: blank mode with LCD off
        lcd_on = 0;
        set_addr(16'h1234, 16'h0000);
        wr_reg(3'd4, 8'h85);
        chk(ctrl_rdata == 8'h86, "R6 refuse", ctrl_rdata, 8'h86);
        wr_reg(3'd4, 8'hFF);
        chk(ctrl_rdata == 8'h80, "R6 refuse wrap", ctrl_rdata, 8'h80);
        clr_counts(); idle(4);
        chk(stall_count == 0, "R6 no stall", stall_count, 0);

        // R9 R10: blank mode, two blocks, held level
        lcd_on = 1;
        wr_reg(3'd4, 8'h81);
        chk(ctrl_rdata == 8'h01, "R7 hb accepted", ctrl_rdata, 8'h01);
        clr_counts(); idle(6);
        chk(stall_count == 0, "R9 waits edge", stall_count, 0);
        pulse_hb(60);
        chk(stall_count == 32 && wr_count == 16, "R9 one block", stall_count, 32);
        chk(ctrl_rdata == 8'h00, "R10 count down", ctrl_rdata, 8'h00);
        clr_counts();
        pulse_hb(1); idle(40);
        chk(wr_count == 16, "R9 second block", wr_count, 16);
        chk(ctrl_rdata == 8'hFF, "R10 final", ctrl_rdata, 8'hFF);

        // R11: cancel between blocks
        wr_reg(3'd4, 8'h83);
        pulse_hb(1); idle(40);
        chk(ctrl_rdata == 8'h02, "R10 partial", ctrl_rdata, 8'h02);
        wr_reg(3'd4, 8'h00);
        chk(ctrl_rdata == 8'h82, "R11 cancel", ctrl_rdata, 8'h82);
        clr_counts();
        pulse_hb(1); idle(40);
        chk(stall_count == 0 && wr_count == 0, "R11 no more", stall_count, 0);
        chk(ctrl_rdata == 8'h82, "R11 held", ctrl_rdata, 8'h82);

        idle(2);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule